// File: doc/BRIEF.md
# Type B Reader Frame Bit Encoder

This block turns a reader command of up to 2^LEN_W-1 bytes into the serial line bit stream that keys the reader's amplitude modulator. A command opens with a pulse on `cmd_start` that carries the byte count on `cmd_len`. The block then asks for the bytes one at a time over a valid/ready handshake. It emits exactly one line bit on every clock cycle in which `bit_en` is high. The stream has a fixed sequence of runs:
- a long run of ones that sets the receiver's reference level;
- a low start-of-frame run;
- the characters, each with a high extra-guard lead-in, a low start bit and eight data bits sent least significant bit first;
- an end-of-frame marker;
- a trailing run of ones that lets the last character leave the modulator before the link turns around to receive.

The command bytes must already include their CRC. The modulator and the receive path sit outside this block. The block holds one byte in a staging register. If the next byte has not arrived by the end of a character's guard, the guard is stretched with further ones, so the line never carries an invalid symbol. A command with zero bytes is legal. It yields a frame with only the framing runs.

Top module: `rdr_frame_serializer`

## Requirements
- R1: Out of reset `line_bit` is 1, and `busy`, `done` and `byte_ready` are 0. `line_bit` stays 1 whenever `busy` is 0.
- R2: A frame begins with 40 one bits followed by 10 zero bits.
- R3: Each byte is sent as two guard bits of value 1, a start bit of value 0 and then the eight data bits, bit 0 first and bit 7 last.
- R4: After the last data bit (or straight after the 10 start-of-frame zeros when the length is 0) the line carries one 1, then 10 zeros, then 8 ones.
- R5: 24 further ones follow the end-of-frame. On the clock edge that emits the last of them, `busy` falls and `done` goes high for exactly one cycle.
- R6: `line_bit` changes only on clock edges where `bit_en` is 1. Each such edge while `busy` is 1 puts out exactly one frame bit.
- R7: A command with `cmd_len` = 0 produces exactly 93 bits (40 + 10 + 1 + 10 + 8 + 24) and requests no byte.
- R8: A `cmd_start` pulse while `busy` is 1 has no effect. The frame in progress, its length and its byte requests are unchanged, and a new command is taken only once `done` has been given.
- R9: `byte_ready` is high only while the one-byte staging register is empty and fewer than `cmd_len` bytes of the current command have been accepted. Exactly `cmd_len` bytes are accepted per command, on cycles where `byte_valid` and `byte_ready` are both 1.
- R10: If a character's two guard bits are complete and no byte is staged, more ones are sent until a byte is staged. Then the start bit and that byte's data follow.
- R11: When every byte is staged in time, a frame of N bytes is 93 + 11·N bits long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-rate enable; one line bit per high cycle |
| cmd_start | input | 1 | Pulse that opens a command; ignored while busy |
| cmd_len | input | LEN_W | Number of bytes in the command, sampled with `cmd_start` |
| byte_valid | input | 1 | Source presents a command byte |
| byte_data | input | 8 | Command byte |
| byte_ready | output | 1 | Encoder can accept a byte this cycle |
| line_bit | output | 1 | Serial bit to the modulator (1 = unmodulated) |
| busy | output | 1 | A frame is being emitted |
| done | output | 1 | One-cycle pulse after the final tail bit |

## Verification
On every cycle the assertions check the following local rules:
- the phase and the line bit move only on enabled edges;
- start-of-frame and start bits are driven low;
- a byte is consumed only when one is staged, and staged data holds until it is consumed;
- the remaining-character count never rises mid-frame;
- `done` is a single-cycle pulse seen only in idle;
- the line is high whenever the block is idle.

Frame-level properties can only be shown by the bench's scenarios, which capture whole frames and parse them against the run lengths. These are the run lengths themselves, the least-significant-first data order, the total frame length, guard stretching when a byte arrives late, and the handling of a start pulse that lands mid-frame.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  // Frame phases in emission order; IDLE emits nothing.
  typedef enum logic [3:0] {
    PH_IDLE,
    PH_PRE,
    PH_SOF,
    PH_GUARD,
    PH_START,
    PH_DATA,
    PH_EOF_MARK,
    PH_EOF_LOW,
    PH_EOF_HIGH,
    PH_TAIL
  } phase_t;

  // Line level put out during a phase; data phases take the shifter LSB.
  function automatic logic phase_level(phase_t p, logic data_lsb);
    case (p)
      PH_SOF, PH_START, PH_EOF_LOW: return 1'b0;
      PH_DATA:                      return data_lsb;
      default:                      return 1'b1;
    endcase
  endfunction

  function automatic int max_of(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // Nominal frame length in bits for n characters with no guard stretch.
  function automatic int frame_bits(int n, int pre, int sof, int guard,
                                    int dbits, int eof_lo, int eof_hi,
                                    int tail);
    return pre + sof + n * (guard + 1 + dbits) + 1 + eof_lo + eof_hi + tail;
  endfunction

endpackage

// File: rtl/rfs_byte_stage.sv
module rfs_byte_stage #(
  parameter int LEN_W     = 6,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arm,
  input  logic [LEN_W-1:0]     arm_len,
  input  logic                 in_valid,
  input  logic [DATA_BITS-1:0] in_data,
  input  logic                 take,
  output logic                 in_ready,
  output logic                 hold_full,
  output logic [DATA_BITS-1:0] hold_data
);

  logic [LEN_W-1:0]     left_q;
  logic                 full_q;
  logic [DATA_BITS-1:0] data_q;
  logic                 accept;

  assign in_ready  = !full_q && (left_q != '0);
  assign accept    = in_valid && in_ready;
  assign hold_full = full_q;
  assign hold_data = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      full_q <= 1'b0;
      data_q <= '0;
    end else if (arm) begin
      left_q <= arm_len;
      full_q <= 1'b0;
    end else begin
      if (accept) begin
        data_q <= in_data;
        full_q <= 1'b1;
        left_q <= left_q - 1'b1;
      end else if (take) begin
        full_q <= 1'b0;
      end
    end
  end

  AST_TAKE_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full_q); // R10

  AST_STAGED_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !take) |=> $stable(data_q)); // R9

endmodule

// File: rtl/rfs_phase_ctrl.sv
module rfs_phase_ctrl
  import rfs_pkg::*;
#(
  parameter int LEN_W     = 6,
  parameter int DATA_BITS = 8,
  parameter int PRE_BITS  = 40,
  parameter int SOF_BITS  = 10,
  parameter int GRD_BITS  = 2,
  parameter int EOFL_BITS = 10,
  parameter int EOFH_BITS = 8,
  parameter int TAIL_BITS = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             start_acc,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             hold_full,
  output phase_t           phase_o,
  output logic             step_o,
  output logic             take_o,
  output logic             done_o
);

  localparam int RUN_MAX = max_of(max_of(max_of(PRE_BITS, SOF_BITS),
                                         max_of(GRD_BITS, DATA_BITS)),
                                  max_of(max_of(EOFL_BITS, EOFH_BITS),
                                         TAIL_BITS));
  localparam int CNT_W = $clog2(RUN_MAX + 1);

  phase_t             phase_q, phase_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [LEN_W-1:0]   chars_q, chars_d;
  logic               done_q, done_d;
  logic               step, take, run_end;

  // Index of the last bit of each phase's run.
  function automatic logic [CNT_W-1:0] run_last(phase_t p);
    case (p)
      PH_PRE:      return CNT_W'(PRE_BITS - 1);
      PH_SOF:      return CNT_W'(SOF_BITS - 1);
      PH_GUARD:    return CNT_W'(GRD_BITS - 1);
      PH_DATA:     return CNT_W'(DATA_BITS - 1);
      PH_EOF_LOW:  return CNT_W'(EOFL_BITS - 1);
      PH_EOF_HIGH: return CNT_W'(EOFH_BITS - 1);
      PH_TAIL:     return CNT_W'(TAIL_BITS - 1);
      default:     return '0;
    endcase
  endfunction

  assign step    = bit_en && (phase_q != PH_IDLE);
  assign run_end = (cnt_q == run_last(phase_q));

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    chars_d = chars_q;
    take    = 1'b0;
    done_d  = 1'b0;
    if (phase_q == PH_IDLE) begin
      if (start_acc) begin
        phase_d = PH_PRE;
        cnt_d   = '0;
        chars_d = cmd_len;
      end
    end else if (step) begin
      if (!run_end) begin
        cnt_d = cnt_q + 1'b1;
      end else begin
        cnt_d = '0;
        case (phase_q)
          PH_PRE:      phase_d = PH_SOF;
          PH_SOF:      phase_d = (chars_q != '0) ? PH_GUARD : PH_EOF_MARK;
          PH_GUARD: begin
            if (hold_full) phase_d = PH_START;
            else           cnt_d   = cnt_q;   // stretch guard with ones
          end
          PH_START: begin
            take    = 1'b1;
            chars_d = chars_q - 1'b1;
            phase_d = PH_DATA;
          end
          PH_DATA:     phase_d = (chars_q != '0) ? PH_GUARD : PH_EOF_MARK;
          PH_EOF_MARK: phase_d = PH_EOF_LOW;
          PH_EOF_LOW:  phase_d = PH_EOF_HIGH;
          PH_EOF_HIGH: phase_d = PH_TAIL;
          PH_TAIL: begin
            phase_d = PH_IDLE;
            done_d  = 1'b1;
          end
          default:     phase_d = PH_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      chars_q <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      chars_q <= chars_d;
      done_q  <= done_d;
    end
  end

  assign phase_o = phase_q;
  assign step_o  = step;
  assign take_o  = take;
  assign done_o  = done_q;

  AST_PHASE_WAITS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && phase_q != PH_IDLE) |=> $stable(phase_q)); // R6

  AST_CHARS_NEVER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |=> (chars_q <= $past(chars_q))); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R5

  AST_DONE_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (phase_q == PH_IDLE)); // R5

endmodule

// File: rtl/rfs_line_gen.sv
module rfs_line_gen
  import rfs_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  phase_t               phase,
  input  logic                 take,
  input  logic [DATA_BITS-1:0] hold_data,
  output logic                 line_bit
);

  logic [DATA_BITS-1:0] shift_q;
  logic                 line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      line_q  <= 1'b1;
    end else if (step) begin
      line_q <= phase_level(phase, shift_q[0]);
      if (take)
        shift_q <= hold_data;
      else if (phase == PH_DATA)
        shift_q <= shift_q >> 1;
    end
  end

  assign line_bit = line_q;

  AST_LINE_ONLY_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(line_q)); // R6

  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (step && phase == PH_START) |=> !line_q); // R3

endmodule

// File: rtl/rdr_frame_serializer.sv
module rdr_frame_serializer
  import rfs_pkg::*;
#(
  parameter int LEN_W     = 6,
  parameter int PRE_BITS  = 40,
  parameter int SOF_BITS  = 10,
  parameter int GRD_BITS  = 2,
  parameter int EOFL_BITS = 10,
  parameter int EOFH_BITS = 8,
  parameter int TAIL_BITS = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             cmd_start,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  output logic             byte_ready,
  output logic             line_bit,
  output logic             busy,
  output logic             done
);

  localparam int DATA_BITS = 8;

  phase_t               phase;
  logic                 step, take, start_acc, hold_full;
  logic [DATA_BITS-1:0] hold_data;

  assign busy      = (phase != PH_IDLE);
  assign start_acc = cmd_start && !busy;

  rfs_byte_stage #(
    .LEN_W(LEN_W), .DATA_BITS(DATA_BITS)
  ) stage_i (
    .clk(clk), .rst_n(rst_n),
    .arm(start_acc), .arm_len(cmd_len),
    .in_valid(byte_valid), .in_data(byte_data),
    .take(take),
    .in_ready(byte_ready), .hold_full(hold_full), .hold_data(hold_data)
  );

  rfs_phase_ctrl #(
    .LEN_W(LEN_W), .DATA_BITS(DATA_BITS),
    .PRE_BITS(PRE_BITS), .SOF_BITS(SOF_BITS), .GRD_BITS(GRD_BITS),
    .EOFL_BITS(EOFL_BITS), .EOFH_BITS(EOFH_BITS), .TAIL_BITS(TAIL_BITS)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .bit_en(bit_en), .start_acc(start_acc), .cmd_len(cmd_len),
    .hold_full(hold_full),
    .phase_o(phase), .step_o(step), .take_o(take), .done_o(done)
  );

  rfs_line_gen #(
    .DATA_BITS(DATA_BITS)
  ) line_i (
    .clk(clk), .rst_n(rst_n),
    .step(step), .phase(phase), .take(take), .hold_data(hold_data),
    .line_bit(line_bit)
  );

  AST_SOF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (step && phase == PH_SOF) |=> !line_bit); // R2

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line_bit); // R1

  AST_NO_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_start) |=> !byte_ready || busy); // R9

endmodule

// File: tb/rdr_frame_serializer_tb_top.sv
module rdr_frame_serializer_tb_top;
  localparam int LEN_W = 6;
  localparam int CAP   = 512;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n, bit_en, cmd_start, byte_valid;
  logic [LEN_W-1:0] cmd_len;
  logic [7:0]       byte_data;
  logic             byte_ready, line_bit, busy, done;

  rdr_frame_serializer #(.LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
    .cmd_start(cmd_start), .cmd_len(cmd_len),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_ready(byte_ready), .line_bit(line_bit),
    .busy(busy), .done(done)
  );

  int   n_cmp = 0, n_bad = 0;
  logic cap [0:CAP-1];
  int   cap_n, done_cnt, done_at, unstable, acc_cnt, extra_ready;
  int   feed_n, stall_idx, stall_cyc;
  logic feed_done;
  logic en_q = 1'b0, busy_q = 1'b0, line_prev = 1'b1;
  logic [7:0] tb_bytes [0:15];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Bit-enable generator (1 in 3 cycles) and line capture.
  initial begin
    int ph;
    ph = 0;
    bit_en = 1'b0;
    forever begin
      @(negedge clk);
      if (en_q && busy_q) begin
        if (cap_n < CAP) cap[cap_n] = line_bit;
        cap_n++;
      end else if (line_bit !== line_prev) begin
        unstable++;
      end
      if (done) begin
        done_cnt++;
        done_at = cap_n;
      end
      if (feed_done && byte_ready) extra_ready++;
      line_prev = line_bit;
      busy_q    = busy;
      ph        = (ph + 1) % 3;
      bit_en    = (ph == 0);
      en_q      = bit_en;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R5 watchdog: actual=%0d expected=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  function automatic int run_len(int from, logic v);
    int k;
    k = from;
    while (k < cap_n && k < CAP && cap[k] === v) k++;
    return k - from;
  endfunction

  task automatic feed();
    for (int i = 0; i < feed_n; i++) begin
      if (i == stall_idx) repeat (stall_cyc) @(negedge clk);
      byte_data  = tb_bytes[i];
      byte_valid = 1'b1;
      while (!byte_ready) @(negedge clk);
      @(negedge clk);
      byte_valid = 1'b0;
      acc_cnt++;
    end
    feed_done = 1'b1;
  endtask

  task automatic start_cmd(int n);
    @(negedge clk);
    cmd_len   = LEN_W'(n);
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic check_frame(int n, bit stalled);
    int p, g, r;
    logic [7:0] d;
    r = run_len(0, 1'b1);  chk(r == 40, "R2", "preamble ones", r, 40);
    p = 40;
    r = run_len(p, 1'b0);  chk(r == 10, "R2", "sof zeros", r, 10);
    p += 10;
    for (int i = 0; i < n; i++) begin
      g = run_len(p, 1'b1);
      if (stalled && i == stall_idx) chk(g > 2, "R10", "stretched guard", g, 3);
      else                           chk(g == 2, "R3", "guard ones", g, 2);
      p += g;
      chk(cap[p] === 1'b0, "R3", "start bit", int'(cap[p]), 0);
      p++;
      for (int b = 0; b < 8; b++) d[b] = cap[p + b];
      chk(d === tb_bytes[i], "R3", "data lsb first", int'(d), int'(tb_bytes[i]));
      p += 8;
    end
    r = run_len(p, 1'b1);  chk(r == 1, "R4", "eof marker", r, 1);
    p += 1;
    r = run_len(p, 1'b0);  chk(r == 10, "R4", "eof zeros", r, 10);
    p += 10;
    r = run_len(p, 1'b1);  chk(r == 32, "R5", "eof high plus tail ones", r, 32);
    p += 32;
    chk(cap_n == p, "R11", "no bits after tail", cap_n, p);
    if (!stalled) chk(cap_n == 93 + 11 * n, "R11", "frame length", cap_n, 93 + 11 * n);
    chk(done_cnt == 1, "R5", "done pulses", done_cnt, 1);
    chk(done_at == cap_n, "R5", "done after last bit", done_at, cap_n);
    chk(busy == 1'b0, "R5", "busy after frame", int'(busy), 0);
    chk(unstable == 0, "R6", "line moved without enable", unstable, 0);
    chk(acc_cnt == n, "R9", "bytes accepted", acc_cnt, n);
    chk(extra_ready == 0 && byte_ready == 1'b0, "R9", "ready after last byte",
        extra_ready + int'(byte_ready), 0);
  endtask

  task automatic run_frame(int n, int s_idx, int s_cyc, bit poke);
    int guard;
    cap_n = 0; done_cnt = 0; done_at = -1; unstable = 0;
    acc_cnt = 0; extra_ready = 0; feed_done = 1'b0;
    feed_n = n; stall_idx = s_idx; stall_cyc = s_cyc;
    start_cmd(n);
    fork feed(); join_none
    if (poke) begin
      repeat (200) @(negedge clk);
      cmd_len = LEN_W'(5); cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0; cmd_len = LEN_W'(n);
    end
    guard = 0;
    while (done_cnt == 0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    repeat (12) @(negedge clk);
    check_frame(n, s_idx < n);
  endtask

  task automatic t_reset();
    chk(line_bit == 1'b1, "R1", "line after reset", int'(line_bit), 1);
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
    chk(byte_ready == 1'b0, "R1", "ready after reset", int'(byte_ready), 0);
  endtask

  task automatic t_empty();
    run_frame(0, 99, 0, 1'b0);
    chk(cap_n == 93, "R7", "empty command length", cap_n, 93);
    chk(acc_cnt == 0, "R7", "empty command byte requests", acc_cnt, 0);
  endtask

  task automatic t_one();
    tb_bytes[0] = 8'hA5;
    run_frame(1, 99, 0, 1'b0);
  endtask

  task automatic t_three();
    tb_bytes[0] = 8'h01; tb_bytes[1] = 8'h80; tb_bytes[2] = 8'hFF;
    run_frame(3, 99, 0, 1'b0);
  endtask

  task automatic t_stall();
    tb_bytes[0] = 8'h3C; tb_bytes[1] = 8'hC3;
    run_frame(2, 1, 300, 1'b0);
    chk(cap_n > 93 + 22, "R10", "stretched frame longer", cap_n, 116);
  endtask

  task automatic t_busy_start();
    tb_bytes[0] = 8'h5A; tb_bytes[1] = 8'h0F;
    run_frame(2, 99, 0, 1'b1);
    chk(acc_cnt == 2, "R8", "mid-frame start ignored", acc_cnt, 2);
    chk(cap_n == 115, "R8", "frame length unchanged", cap_n, 115);
  endtask

  initial begin
    rst_n = 1'b0; cmd_start = 1'b0; cmd_len = '0;
    byte_valid = 1'b0; byte_data = '0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_empty();
    t_one();
    t_three();
    t_stall();
    t_busy_start();
    t_one();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule